// File: doc/BRIEF.md
# SPI flash command engine

This block is a register-driven SPI master for serial flash. Software programs an opcode, an action code and a chip-select-hold flag in a control register, loads a 24-bit flash address into an address register, and writes the control register with its start bit set. The engine then clocks one frame out on a single data lane in SPI mode 0. Each frame begins with the opcode, then sends three address bytes, then sends zero filler. It stops right after the last received byte that the action code needs. That byte, or a four-byte window of the returned stream, is stored in the data register in little-endian lane order.

With the chip-select-hold flag set, each start sends only the opcode byte and captures the byte returned alongside it. Chip select then stays low after the frame, so software can stream a command and its data one byte per start. When software clears the flag, chip select is released.

The sequencer has four states. IDLE waits for a start. LEAD holds SCK low for half a period after chip select falls. SHIFT toggles SCK once per half period through every bit of the frame. TAIL keeps chip select low for one full SCK period after the last falling edge. The transitions are named as follows. IDLE→LEAD is an accepted start. LEAD→SHIFT is the first rising edge. SHIFT→TAIL is the last falling edge of a frame without hold. SHIFT→IDLE is the last falling edge of a held frame. TAIL→IDLE is the end of the period.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck and spi_mosi are 0, and all three registers read 0.
- R2: The register offsets are 0x0 for control, 0x4 for address and 0x8 for data. Control reads as {busy at bit 31, zeros, hold at bit 12, 0, action at bits 10:8, opcode at bits 7:0}. The address and data registers are writable at any time and read back what was written. A capture and a data write in the same cycle resolve to the capture.
- R3: A control write with bit 31 set while idle starts a frame, and bit 31 reads 1 from the next cycle. A control write while busy is ignored entirely: fields, start and frame are all unaffected.
- R4: Without hold, the frame length in bytes is set by the action code: 0→1, 1→2, 6→3, 2→4, 3→5, 4→8, 7→9, 5→12. With hold, the frame is always 1 byte.
- R5: MOSI sends byte 1 as the opcode. Without hold, bytes 2, 3 and 4 are address bits [23:16], [15:8] and [7:0], with the address sampled at the start. All later bytes are 0x00. Every byte is sent MSB-first. MOSI is 0 outside the shifting phase.
- R6: Timing is mode 0 with SCK period CLK_DIV cycles. SCK idles low. The first rising edge comes CLK_DIV/2 cycles after the start is accepted. MOSI changes only at falling edges, and MISO is sampled at rising edges.
- R7: Single-byte actions capture into data[7:0] with the upper bits zero. Action 0 captures byte 1, action 1 byte 2, action 6 byte 3, action 2 byte 4 and action 3 byte 5. The data register updates at the rising edge of that byte's last bit.
- R8: Window actions capture 4 bytes: action 4 takes bytes 5–8, action 5 bytes 9–12 and action 7 bytes 6–9. The first byte of the window goes to data[7:0] and the fourth to data[31:24].
- R9: Without hold, chip select stays low for CLK_DIV cycles after the last falling SCK edge. It then rises in the same cycle that busy clears.
- R10: With hold, the one-byte frame captures the returned byte into data[7:0]. Busy clears at the last falling edge. While idle, spi_cs_n is the inverse of the stored hold bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Take E0 as the edge that accepts a start and t as the number of edges since E0. SCK is high when t ≥ CLK_DIV/2, t < 8N·CLK_DIV and (t − CLK_DIV/2) mod CLK_DIV < CLK_DIV/2. MOSI carries bit ⌊t/CLK_DIV⌋ while t < 8N·CLK_DIV. The data register changes at t = CLK_DIV/2 + (8N−1)·CLK_DIV. Busy clears at t = 8N·CLK_DIV with hold, and otherwise one period later, when chip select also rises. The reference model advances t at each rising edge, and the bench compares SCK, chip select, MOSI and busy one nanosecond after every edge. Register reads are made mid-cycle against model state.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int REG_W     = 32;
    localparam int MAX_BYTES = 12;
    localparam int BIT_W     = $clog2(MAX_BYTES * 8);
    localparam int BYTE_W    = BIT_W - 3;

    // control field positions (software-visible map)
    localparam int OPC_LSB = 0;
    localparam int ACT_LSB = 8;
    localparam int HLD_BIT = 12;
    localparam int GO_BIT  = 31;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_ADDR = 4'h4;
    localparam logic [3:0] OFF_DATA = 4'h8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL
    } eng_state_t;

    typedef struct packed {
        logic       hold;
        logic [2:0] action;
        logic [7:0] opcode;
    } ctrl_t;

    // frame length in bytes for an action code
    function automatic logic [BYTE_W-1:0] frame_bytes(input logic [2:0] act, input logic hold);
        logic [BYTE_W-1:0] n;
        if (hold) begin
            n = BYTE_W'(1);
        end else begin
            unique case (act)
                3'd0: n = BYTE_W'(1);
                3'd1: n = BYTE_W'(2);
                3'd6: n = BYTE_W'(3);
                3'd2: n = BYTE_W'(4);
                3'd3: n = BYTE_W'(5);
                3'd4: n = BYTE_W'(8);
                3'd7: n = BYTE_W'(9);
                default: n = BYTE_W'(12);
            endcase
        end
        return n;
    endfunction

    function automatic logic is_window(input logic [2:0] act, input logic hold);
        return !hold && (act == 3'd4 || act == 3'd5 || act == 3'd7);
    endfunction

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [3:0]       addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             busy_i,
    input  logic             cap_valid_i,
    input  logic [REG_W-1:0] cap_data_i,
    output ctrl_t            ctrl_o,
    output logic [REG_W-1:0] faddr_o,
    output logic             start_o,
    output logic [REG_W-1:0] rdata_o
);

    ctrl_t            ctrl_q;
    logic [REG_W-1:0] faddr_q;
    logic [REG_W-1:0] data_q;
    logic             ctrl_wr;

    assign ctrl_wr = we_i && (addr_i == OFF_CTRL) && !busy_i;
    assign start_o = ctrl_wr && wdata_i[GO_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            faddr_q <= '0;
            data_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.opcode <= wdata_i[OPC_LSB +: 8];
                ctrl_q.action <= wdata_i[ACT_LSB +: 3];
                ctrl_q.hold   <= wdata_i[HLD_BIT];
            end
            if (we_i && addr_i == OFF_ADDR) begin
                faddr_q <= wdata_i;
            end
            if (cap_valid_i) begin
                data_q <= cap_data_i;
            end else if (we_i && addr_i == OFF_DATA) begin
                data_q <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == OFF_CTRL) begin
            rdata_o[GO_BIT]           = busy_i;
            rdata_o[HLD_BIT]          = ctrl_q.hold;
            rdata_o[ACT_LSB +: 3]     = ctrl_q.action;
            rdata_o[OPC_LSB +: 8]     = ctrl_q.opcode;
        end else if (addr_i == OFF_ADDR) begin
            rdata_o = faddr_q;
        end else if (addr_i == OFF_DATA) begin
            rdata_o = data_q;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign faddr_o = faddr_q;

endmodule

// File: rtl/spi_eng_fsm.sv
module spi_eng_fsm
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              hold_i,
    input  logic [BYTE_W-1:0] nbytes_i,
    output logic              busy_o,
    output logic              sck_o,
    output logic              frame_on_o,
    output logic              rise_o,
    output logic              fall_o,
    output logic              last_o,
    output logic [BIT_W-1:0]  bit_idx_o
);

    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(CLK_DIV - 1);

    eng_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sck_q, sck_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic [BIT_W-1:0] last_bit;

    assign last_bit = {nbytes_i, 3'b000} - BIT_W'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sck_q   <= 1'b0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sck_q   <= sck_d;
            bit_q   <= bit_d;
        end
    end

    // transitions and edge strobes
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sck_d   = sck_q;
        bit_d   = bit_q;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_LEAD;
                    cnt_d   = '0;
                    bit_d   = '0;
                end
            end
            ST_LEAD: begin
                if (cnt_q == HALF_M1) begin
                    state_d = ST_SHIFT;
                    cnt_d   = '0;
                    sck_d   = 1'b1;
                    rise_o  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                if (cnt_q == HALF_M1) begin
                    cnt_d = '0;
                    if (sck_q) begin
                        sck_d  = 1'b0;
                        fall_o = 1'b1;
                        if (bit_q == last_bit) begin
                            last_o  = 1'b1;
                            state_d = hold_i ? ST_IDLE : ST_TAIL;
                        end else begin
                            bit_d = bit_q + BIT_W'(1);
                        end
                    end else begin
                        sck_d  = 1'b1;
                        rise_o = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_TAIL: begin
                if (cnt_q == FULL_M1) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        frame_on_o = (state_q == ST_LEAD) || (state_q == ST_SHIFT);
        sck_o      = sck_q;
        bit_idx_o  = bit_q;
    end

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       opcode_i,
    input  logic [23:0]      faddr_i,
    input  logic             hold_i,
    input  logic [2:0]       action_i,
    input  logic             frame_on_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             last_i,
    input  logic [BIT_W-1:0] bit_idx_i,
    input  logic             miso_i,
    output logic             mosi_o,
    output logic             cap_valid_o,
    output logic [REG_W-1:0] cap_data_o
);

    logic [7:0]        tx_q;
    logic [7:0]        rx_q;
    logic [23:0]       asnap_q;
    logic [7:0]        rx_byte;
    logic              byte_done;
    logic              byte_end;
    logic [BYTE_W-1:0] rx_num;
    logic [BYTE_W-1:0] tx_num;
    logic [BYTE_W-1:0] win_first;
    logic              wide;
    logic [23:0]       acc_w;

    assign rx_byte   = {rx_q[6:0], miso_i};
    assign byte_end  = (bit_idx_i[2:0] == 3'd7);
    assign byte_done = rise_i && byte_end;
    assign rx_num    = bit_idx_i[BIT_W-1:3] + BYTE_W'(1);
    assign tx_num    = bit_idx_i[BIT_W-1:3] + BYTE_W'(2);
    assign wide      = is_window(action_i, hold_i);
    assign win_first = frame_bytes(action_i, hold_i) - BYTE_W'(3);

    function automatic logic [7:0] tx_byte(input logic [BYTE_W-1:0] k,
                                           input logic hold,
                                           input logic [23:0] a);
        logic [7:0] b;
        b = 8'h00;
        if (!hold) begin
            if (k == BYTE_W'(2))      b = a[23:16];
            else if (k == BYTE_W'(3)) b = a[15:8];
            else if (k == BYTE_W'(4)) b = a[7:0];
        end
        return b;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_q    <= '0;
            asnap_q <= '0;
        end else begin
            if (start_i) begin
                tx_q    <= opcode_i;
                asnap_q <= faddr_i;
            end else if (fall_i && !last_i) begin
                if (byte_end) tx_q <= tx_byte(tx_num, hold_i, asnap_q);
                else          tx_q <= {tx_q[6:0], 1'b0};
            end
            if (rise_i) begin
                rx_q <= rx_byte;
            end
        end
    end

    // window accumulator lanes (lanes 0..2; lane 3 comes straight from the wire)
    for (genvar g = 0; g < 3; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (byte_done && wide && rx_num == win_first + BYTE_W'(g)) begin
                lane_q <= rx_byte;
            end
        end
        assign acc_w[g*8 +: 8] = lane_q;
    end

    assign cap_valid_o = byte_done && (rx_num == frame_bytes(action_i, hold_i));
    assign cap_data_o  = wide ? {rx_byte, acc_w} : {24'h0, rx_byte};
    assign mosi_o      = frame_on_i ? tx_q[7] : 1'b0;

endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    ctrl_t             ctrl_q;
    logic [REG_W-1:0]  faddr_q;
    logic              start;
    logic              eng_busy;
    logic              frame_on;
    logic              rise;
    logic              fall;
    logic              last;
    logic [BIT_W-1:0]  bit_idx;
    logic              cap_valid;
    logic [REG_W-1:0]  cap_data;
    logic              ctrl_hold;
    logic [7:0]        ctrl_opcode;

    assign ctrl_hold   = ctrl_q.hold;
    assign ctrl_opcode = ctrl_q.opcode;

    spi_eng_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (reg_we),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .busy_i      (eng_busy),
        .cap_valid_i (cap_valid),
        .cap_data_i  (cap_data),
        .ctrl_o      (ctrl_q),
        .faddr_o     (faddr_q),
        .start_o     (start),
        .rdata_o     (reg_rdata)
    );

    spi_eng_fsm #(.CLK_DIV(CLK_DIV)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .hold_i     (ctrl_q.hold),
        .nbytes_i   (frame_bytes(ctrl_q.action, ctrl_q.hold)),
        .busy_o     (eng_busy),
        .sck_o      (spi_sck),
        .frame_on_o (frame_on),
        .rise_o     (rise),
        .fall_o     (fall),
        .last_o     (last),
        .bit_idx_o  (bit_idx)
    );

    spi_eng_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .opcode_i    (reg_wdata[OPC_LSB +: 8]),
        .faddr_i     (faddr_q[23:0]),
        .hold_i      (ctrl_q.hold),
        .action_i    (ctrl_q.action),
        .frame_on_i  (frame_on),
        .rise_i      (rise),
        .fall_i      (fall),
        .last_i      (last),
        .bit_idx_i   (bit_idx),
        .miso_i      (spi_miso),
        .mosi_o      (spi_mosi),
        .cap_valid_o (cap_valid),
        .cap_data_o  (cap_data)
    );

    assign spi_cs_n = !(eng_busy || ctrl_q.hold);

endmodule

// File: rtl/spi_eng_checker.sv
module spi_eng_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        sck,
    input logic        cs_n,
    input logic        mosi,
    input logic        hold,
    input logic [7:0]  opcode,
    input logic        reg_we,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata
);

    a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    a_r5_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 4'h0 && reg_wdata[31] && !busy) |=> busy);

    a_r3_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == 4'h0) |=> $stable(opcode));

    a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    a_r9_cs_low_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    a_r10_hold_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && hold) |-> !cs_n);

endmodule

bind spi_flash_engine spi_eng_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (eng_busy),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .hold      (ctrl_hold),
    .opcode    (ctrl_opcode),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/spi_flash_engine_tb.sv
`timescale 1ns/1ps
module spi_flash_engine_tb;

    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    spi_flash_engine #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- requirement helpers ----------------
    function automatic int flen(input int act, input bit hold);
        if (hold) return 1;
        case (act)
            0: return 1; 1: return 2; 6: return 3; 2: return 4;
            3: return 5; 4: return 8; 7: return 9; default: return 12;
        endcase
    endfunction

    function automatic logic [7:0] pat(input int s, input int k);
        return 8'((s * 29 + k * 53) ^ 8'hA5);
    endfunction

    function automatic logic [31:0] exp_cap(input int act, input bit hold, input int s);
        int n;
        n = flen(act, hold);
        if (!hold && (act == 4 || act == 5 || act == 7))
            return {pat(s, n), pat(s, n - 1), pat(s, n - 2), pat(s, n - 3)};
        return {24'h0, pat(s, n)};
    endfunction

    // ---------------- flash-side responder ----------------
    int seed = 0;
    int sb = 0;
    always @(negedge spi_sck) sb = sb + 1;
    always_comb spi_miso = pat(seed, sb / 8 + 1)[7 - (sb % 8)];

    // ---------------- reference model ----------------
    bit          m_busy, m_cs, m_hold;
    int          m_t, m_n, m_tcap;
    logic [7:0]  m_op;
    logic [2:0]  m_act;
    logic [31:0] m_addr, m_snap, m_data, m_capv;

    function automatic logic [7:0] m_txbyte(input int k);
        if (k == 1) return m_op;
        if (m_hold) return 8'h00;
        if (k == 2) return m_snap[23:16];
        if (k == 3) return m_snap[15:8];
        if (k == 4) return m_snap[7:0];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        bit old_busy;
        if (!rst_n) begin
            m_busy = 0; m_cs = 0; m_hold = 0; m_t = 0; m_n = 1; m_tcap = -1;
            m_op = 0; m_act = 0; m_addr = 0; m_snap = 0; m_data = 0; m_capv = 0;
        end else begin
            old_busy = m_busy;
            if (reg_we && reg_addr == 4'h4) m_addr = reg_wdata;
            if (reg_we && reg_addr == 4'h8) m_data = reg_wdata;
            if (old_busy) begin
                m_t = m_t + 1;
                if (m_t == m_tcap) m_data = m_capv;
                if (m_hold && m_t == m_n * 8 * DIV) m_busy = 0;
                if (!m_hold && m_t == m_n * 8 * DIV + DIV) m_busy = 0;
            end
            if (reg_we && reg_addr == 4'h0 && !old_busy) begin
                m_op  = reg_wdata[7:0];
                m_act = reg_wdata[10:8];
                m_cs  = reg_wdata[12];
                if (reg_wdata[31]) begin
                    m_busy = 1; m_t = 0; m_hold = m_cs;
                    m_n    = flen(m_act, m_hold);
                    m_snap = m_addr;
                    m_tcap = HALF + (8 * m_n - 1) * DIV;
                    m_capv = exp_cap(m_act, m_hold, seed);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit e_sck, e_mosi;
            int b;
            e_sck  = m_busy && m_t >= HALF && m_t < m_n * 8 * DIV && ((m_t - HALF) % DIV) < HALF;
            e_mosi = 0;
            if (m_busy && m_t < m_n * 8 * DIV) begin
                b = m_t / DIV;
                e_mosi = m_txbyte(b / 8 + 1)[7 - (b % 8)];
            end
            chk("R6 sck", 32'(spi_sck), 32'(e_sck));
            chk("R5 mosi", 32'(spi_mosi), 32'(e_mosi));
            chk("R9/R10 cs_n", 32'(spi_cs_n), 32'(m_busy ? 1'b0 : !m_cs));
            if (reg_addr == 4'h0) chk("R3 busy", 32'(reg_rdata[31]), 32'(m_busy));
        end
    end

    // ---------------- drivers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_addr = 4'h0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
        @(negedge clk);
        reg_addr = 4'h0;
    endtask

    function automatic logic [31:0] ctl(input bit go, input bit hold, input int act, input logic [7:0] op);
        return {go, 18'h0, hold, 1'b0, 3'(act), op};
    endfunction

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (m_busy && guard < 5000);
    endtask

    task automatic launch(input int act, input bit hold, input logic [7:0] op, input int s);
        @(negedge clk);
        seed = s; sb = 0;
        wr(4'h0, ctl(1, hold, act, op));
    endtask

    task automatic run(input string tag, input int act, input bit hold, input logic [7:0] op, input int s);
        launch(act, hold, op, s);
        wait_idle();
        rd({tag, " data"}, 4'h8, exp_cap(act, hold, s));
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk("R1 cs_n", 32'(spi_cs_n), 32'd1);
        chk("R1 sck", 32'(spi_sck), 32'd0);
        chk("R1 mosi", 32'(spi_mosi), 32'd0);
        rd("R1 ctrl", 4'h0, 32'h0);
        rd("R1 addr", 4'h4, 32'h0);
        rd("R1 data", 4'h8, 32'h0);

        // R2 register map
        wr(4'h4, 32'hA1B2C3D4);
        rd("R2 addr", 4'h4, 32'hA1B2C3D4);
        wr(4'h8, 32'hCAFEF00D);
        rd("R2 data", 4'h8, 32'hCAFEF00D);
        wr(4'h0, ctl(0, 0, 5, 8'h3C));
        rd("R2 ctrl", 4'h0, ctl(0, 0, 5, 8'h3C));

        // R4 R7 single-byte actions
        wr(4'h4, 32'h00123456);
        run("R7 act0", 0, 0, 8'h9F, 3);
        run("R7 act1", 1, 0, 8'h05, 7);
        run("R7 act6", 6, 0, 8'h0B, 11);
        run("R7 act2", 2, 0, 8'h03, 17);
        wr(4'h4, 32'h00FE01A5);
        run("R7 act3", 3, 0, 8'hAB, 23);
        // R8 windows
        run("R8 act4", 4, 0, 8'h03, 31);
        run("R8 act5", 5, 0, 8'h0B, 41);
        run("R8 act7", 7, 0, 8'h3B, 53);

        // R3 ignored start while busy; R2 addr write while busy; R5 snapshot
        launch(4, 0, 8'h6B, 61);
        repeat (20) @(negedge clk);
        wr(4'h0, ctl(1, 1, 0, 8'h9F));
        wr(4'h4, 32'h00777777);
        wait_idle();
        rd("R3 ctrl unchanged", 4'h0, ctl(0, 0, 4, 8'h6B));
        rd("R8 data after ignored start", 4'h8, exp_cap(4, 0, 61));
        rd("R2 addr while busy", 4'h4, 32'h00777777);

        // R10 hold mode
        wr(4'h0, ctl(0, 1, 0, 8'h00));
        @(negedge clk);
        chk("R10 cs held idle", 32'(spi_cs_n), 32'd0);
        run("R10 hold byte A", 3, 1, 8'h06, 71);
        @(negedge clk);
        chk("R10 cs after frame", 32'(spi_cs_n), 32'd0);
        run("R10 hold byte B", 0, 1, 8'h02, 83);
        wr(4'h0, ctl(0, 0, 0, 8'h02));
        @(negedge clk);
        chk("R10 cs released", 32'(spi_cs_n), 32'd1);

        // R9 frame after hold release
        run("R9 act1 post-hold", 1, 0, 8'hC7, 97);
        repeat (4) @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule